// File: doc/BRIEF.md
# Single-Cycle Core Control Decoder

This block is the control unit of a single-cycle processor core. It is purely combinational. It reads the 6-bit major opcode and the 6-bit function field of the instruction being executed, plus the zero flag from the ALU. From these it drives every steering and enable signal the datapath needs for that same cycle.

The decoder is flat. For register-register instructions it maps the function field straight to a 3-bit ALU operation code, with no separate second-level ALU controller. It also makes the next-PC select itself, by combining the branch-if-equal decode with the zero flag.

Any opcode it does not know, and any unknown function field within the register-register group, is treated as a no-operation. In that case every output is driven low, so nothing is written and no branch is taken.

Top module: `ctl_decoder`

## Requirements
- R1: With opcode 000000 and a supported function field, `dst_from_rd`=1, `reg_we`=1, `imm_sel`=0, `load_sel`=0, `mem_we`=0, `mem_re`=0 and `branch_take`=0.
- R2: With opcode 000000, the function field sets `alu_ctl` as follows: 100100 gives 000, 100101 gives 001, 100000 gives 010, 100010 gives 110 and 101010 gives 111.
- R3: With opcode 100011 (load word), `alu_ctl`=010, `imm_sel`=1, `mem_re`=1, `load_sel`=1, `reg_we`=1, and `dst_from_rd`=0, `mem_we`=0, `branch_take`=0.
- R4: With opcode 101011 (store word), `alu_ctl`=010, `imm_sel`=1 and `mem_we`=1. `reg_we`, `mem_re`, `dst_from_rd`, `load_sel` and `branch_take` are all 0.
- R5: With opcode 000100 (branch if equal), `alu_ctl`=110 and all of `reg_we`, `mem_we`, `mem_re`, `imm_sel`, `dst_from_rd` and `load_sel` are 0.
- R6: `branch_take` is 1 exactly when the opcode is 000100 and `alu_zero` is 1.
- R7: Any opcode other than 000000, 100011, 101011 and 000100 drives all ten output bits to 0.
- R8: Opcode 000000 with a function field outside the five listed in R2 drives all ten output bits to 0.
- R9: The function field has no effect on any output unless the opcode is 000000. `alu_zero` has no effect on any output unless the opcode is 000100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Major opcode of the current instruction |
| fn_code | input | 6 | Function field of the current instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| dst_from_rd | output | 1 | Destination register taken from the rd field (0 selects rt) |
| reg_we | output | 1 | Register file write enable |
| imm_sel | output | 1 | Second ALU operand is the sign-extended immediate |
| alu_ctl | output | 3 | ALU operation code |
| mem_we | output | 1 | Data memory write enable |
| mem_re | output | 1 | Data memory read enable |
| load_sel | output | 1 | Register write data comes from memory (0 selects the ALU result) |
| branch_take | output | 1 | Next PC is the branch target |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same clock cycle as its stimulus, with no register in the path. The bench changes the inputs just after a rising edge. It compares all ten outputs with its own model at the following falling edge, which is half a period later, when the combinational paths have settled. The sweep covers every opcode and function-field pair with both zero-flag values. Directed vectors then pin down the named instructions and show that the fields declared irrelevant leave the outputs unchanged.

// File: rtl/ctl_decoder.sv
module ctl_decoder (
  input  logic [5:0] op_code,
  input  logic [5:0] fn_code,
  input  logic       alu_zero,
  output logic       dst_from_rd,
  output logic       reg_we,
  output logic       imm_sel,
  output logic [2:0] alu_ctl,
  output logic       mem_we,
  output logic       mem_re,
  output logic       load_sel,
  output logic       branch_take
);
  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  logic       fn_ok;
  logic [2:0] fn_alu;
  logic       is_reg, is_load, is_store, is_beq;

  always_comb begin
    fn_ok  = 1'b1;
    fn_alu = ALU_AND;
    case (fn_code)
      FN_ADD:  fn_alu = ALU_ADD;
      FN_SUB:  fn_alu = ALU_SUB;
      FN_AND:  fn_alu = ALU_AND;
      FN_OR:   fn_alu = ALU_OR;
      FN_SLT:  fn_alu = ALU_SLT;
      default: fn_ok  = 1'b0;
    endcase
  end

  assign is_reg   = (op_code == OPC_REG) && fn_ok;
  assign is_load  = (op_code == OPC_LOAD);
  assign is_store = (op_code == OPC_STORE);
  assign is_beq   = (op_code == OPC_BEQ);

  assign dst_from_rd = is_reg;
  assign reg_we      = is_reg | is_load;
  assign imm_sel     = is_load | is_store;
  assign mem_we      = is_store;
  assign mem_re      = is_load;
  assign load_sel    = is_load;
  assign branch_take = is_beq & alu_zero;

  always_comb begin
    if (is_reg)                  alu_ctl = fn_alu;
    else if (is_load | is_store) alu_ctl = ALU_ADD;
    else if (is_beq)             alu_ctl = ALU_SUB;
    else                         alu_ctl = 3'b000;
  end

  always_comb begin
    p_branch_needs_zero_r6: assert (!branch_take || alu_zero);
    p_branch_is_sub_r5:     assert (!branch_take || (alu_ctl == ALU_SUB && !reg_we && !mem_we));
    p_store_no_write_r4:    assert (!(mem_we && (reg_we || mem_re || load_sel)));
    p_load_path_r3:         assert (!mem_re || (load_sel && imm_sel && reg_we && !dst_from_rd && alu_ctl == ALU_ADD));
    p_reg_path_r1:          assert (!dst_from_rd || (reg_we && !imm_sel && !load_sel && !mem_we));
    p_unknown_quiet_r7:     assert (!(op_code != OPC_REG && op_code != OPC_LOAD && op_code != OPC_STORE
                                      && op_code != OPC_BEQ) || !(reg_we || mem_we || mem_re || branch_take));
  end
endmodule

// File: tb/sim_ctl_decoder.sv
module sim_ctl_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0] op_code = 6'd0;
  logic [5:0] fn_code = 6'd0;
  logic       alu_zero = 1'b0;
  logic dst_from_rd, reg_we, imm_sel, mem_we, mem_re, load_sel, branch_take;
  logic [2:0] alu_ctl;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  ctl_decoder u0 (
    .op_code(op_code), .fn_code(fn_code), .alu_zero(alu_zero),
    .dst_from_rd(dst_from_rd), .reg_we(reg_we), .imm_sel(imm_sel),
    .alu_ctl(alu_ctl), .mem_we(mem_we), .mem_re(mem_re),
    .load_sel(load_sel), .branch_take(branch_take)
  );

  // Expected word: {dst, we, imm, alu[2:0], mwe, mre, ldsel, br}
  function automatic logic [9:0] model(input int op, input int fn, input bit z);
    int alu;
    alu = -1;
    if (op == 0) begin
      if (fn == 32) alu = 2;
      else if (fn == 34) alu = 6;
      else if (fn == 36) alu = 0;
      else if (fn == 37) alu = 1;
      else if (fn == 42) alu = 7;
      if (alu < 0) return 10'd0;
      return {3'b110, 3'(alu), 4'b0000};
    end
    if (op == 35) return {3'b011, 3'd2, 4'b0110};
    if (op == 43) return {3'b001, 3'd2, 4'b1000};
    if (op == 4)  return {3'b000, 3'd6, 3'b000, z};
    return 10'd0;
  endfunction

  function automatic string tag_of(input int op, input int fn, input bit z);
    if (op == 0) return (model(0, fn, 0) == 10'd0) ? "R8" : "R1/R2";
    if (op == 35) return "R3";
    if (op == 43) return "R4";
    if (op == 4) return z ? "R6" : "R5";
    return "R7";
  endfunction

  task automatic apply_check(input int op, input int fn, input bit z, input string tag);
    logic [9:0] got, exp;
    @(posedge clk);
    op_code = 6'(op); fn_code = 6'(fn); alu_zero = z;
    @(negedge clk);
    got = {dst_from_rd, reg_we, imm_sel, alu_ctl, mem_we, mem_re, load_sel, branch_take};
    exp = model(op, fn, z);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%b fn=%b z=%0d got=%b exp=%b", tag, 6'(op), 6'(fn), z, got, exp);
    end
  endtask

  initial begin
    // reset-state check: inputs all zero is R-type with unknown func
    apply_check(0, 0, 0, "R8");
    // directed named vectors
    apply_check(0, 32, 0, "R2"); apply_check(0, 34, 1, "R2");
    apply_check(0, 36, 0, "R2"); apply_check(0, 37, 0, "R2");
    apply_check(0, 42, 1, "R1");
    apply_check(35, 0, 0, "R3"); apply_check(43, 0, 0, "R4");
    apply_check(4, 0, 0, "R5");  apply_check(4, 0, 1, "R6");
    apply_check(2, 32, 1, "R7"); apply_check(0, 63, 1, "R8");
    // R9: irrelevant fields must not move outputs
    for (int f = 0; f < 64; f += 7) begin
      apply_check(35, f, 1, "R9");
      apply_check(43, f, 1, "R9");
      apply_check(4, f, 1, "R9");
      apply_check(0, 32, f[0], "R9");
    end
    // exhaustive sweep
    for (int op = 0; op < 64; op++)
      for (int fn = 0; fn < 64; fn++)
        for (int z = 0; z < 2; z++)
          apply_check(op, fn, z[0], tag_of(op, fn, z[0]));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule